// File: doc/BRIEF.md
# ALU Flag Unit with Branch Predicate Evaluator

This block combines a 64-bit add/subtract/logical unit with a four-bit status register and a branch predicate evaluator. A caller presents two operands and an operation code with a valid strobe. One clock edge later the block shows the computed value and a write-enable for a destination. At the same edge the carry, zero, sign and overflow flags are captured. A compare operation updates the flags like a subtraction, but it raises no write-enable and leaves the held result untouched.

A separate 4-bit condition select picks one predicate: unconditional, equality, sign, signed ordering or unsigned ordering. The take-branch output is a purely combinational function of the registered flags and that select. A branch that follows a compare therefore sees the new flags in the cycle after the compare was accepted.

The block has no state machine. It has three registered items: the flags, the result and the write strobe. Each changes only when an operation is accepted.

Top module: `flag_branch_unit`

## Requirements
- R1: After reset all four flags are 0, the result is 0, result_we is 0, and the unconditional predicate (code 0) reads 1 while equality (code 1) reads 0.
- R2: Op code 0 (add) yields a+b mod 2^64 with result_we=1; CF is the carry out of bit 63 and OF is set when both operands share a sign that the sum does not.
- R3: Op code 1 (subtract) yields a-b with result_we=1; CF is set when a<b as unsigned numbers, and OF is set when the true signed difference cannot be represented in 64 bits.
- R4: Op code 2 (compare) sets the flags exactly as subtract does, drives result_we=0 and leaves the result output unchanged.
- R5: For every accepted op other than compare, ZF is 1 exactly when the result is zero and SF equals result bit 63; for compare they describe a-b.
- R6: Op codes 3 (and), 4 (or) and 5 (xor) produce the bitwise result with result_we=1 and clear CF and OF.
- R7: With op_valid low, and for the unused op codes 6 and 7, the flags and the result keep their values and result_we is 0.
- R8: The result, result_we and flags for an op accepted at a clock edge are visible after that edge. Back-to-back ops each appear one cycle apart, and result_we drops in the cycle after an idle edge.
- R9: Condition codes 0 always, 1 ZF, 2 ~ZF, 3 SF, 4 ~SF drive take_branch.
- R10: Signed codes: 5 greater ~(SF^OF)&~ZF, 6 greater-or-equal ~(SF^OF), 7 less SF^OF, 8 less-or-equal (SF^OF)|ZF.
- R11: Unsigned codes: 9 above ~CF&~ZF, 10 below CF; codes 11 to 15 never take the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accept the operation this cycle |
| op_sel | input | 3 | Operation code |
| opnd_a | input | 64 | First operand (minuend) |
| opnd_b | input | 64 | Second operand (subtrahend) |
| cond_sel | input | 4 | Branch predicate select |
| result | output | 64 | Last written result |
| result_we | output | 1 | Destination write strobe, one cycle per writing op |
| flag_c | output | 1 | Carry/borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_o | output | 1 | Signed overflow flag |
| take_branch | output | 1 | Selected predicate on the stored flags |

## Verification
Result, result_we and all four flags are due one edge after the op is accepted. The driver pushes each expectation as it drives a valid op. The monitor pops it at the falling edge after the next rising edge, and in every cycle with nothing due it checks that result_we is low. take_branch has no latency relative to cond_sel. Each predicate is therefore sampled a moment after cond_sel changes, in a falling-edge slot where no op is being accepted. Expected predicates come from direct signed and unsigned comparisons of the compared operands, not from the flags.

// File: rtl/fl_pkg.sv
package fl_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CMP  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'd0,
        CC_EQ     = 4'd1,
        CC_NE     = 4'd2,
        CC_NEG    = 4'd3,
        CC_NNEG   = 4'd4,
        CC_SGT    = 4'd5,
        CC_SGE    = 4'd6,
        CC_SLT    = 4'd7,
        CC_SLE    = 4'd8,
        CC_UGT    = 4'd9,
        CC_ULT    = 4'd10
    } cc_e;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic o;
    } flags_t;

    localparam int CC_W     = 4;
    localparam int CC_COUNT = 1 << CC_W;

    function automatic logic cc_eval(input logic [CC_W-1:0] code, input flags_t f);
        logic lt;
        lt = f.s ^ f.o;
        case (code)
            CC_ALWAYS: return 1'b1;
            CC_EQ:     return f.z;
            CC_NE:     return ~f.z;
            CC_NEG:    return f.s;
            CC_NNEG:   return ~f.s;
            CC_SGT:    return ~lt & ~f.z;
            CC_SGE:    return ~lt;
            CC_SLT:    return lt;
            CC_SLE:    return lt | f.z;
            CC_UGT:    return ~f.c & ~f.z;
            CC_ULT:    return f.c;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fl_arith.sv
module fl_arith
    import fl_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              op_valid,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] value,
    output flags_t            next_flags,
    output logic              upd_flags,
    output logic              wr_dest
);
    localparam int MSB = DATA_W - 1;

    op_e              op;
    logic [DATA_W:0]  sum_ext;
    logic [DATA_W:0]  dif_ext;
    logic             add_ovf;
    logic             sub_ovf;
    logic             cy;
    logic             ov;
    logic             known;

    assign op      = op_e'(op_sel);
    assign sum_ext = {1'b0, a} + {1'b0, b};
    assign dif_ext = {1'b0, a} - {1'b0, b};
    assign add_ovf = (a[MSB] == b[MSB]) && (sum_ext[MSB] != a[MSB]);
    assign sub_ovf = (a[MSB] != b[MSB]) && (dif_ext[MSB] != a[MSB]);

    always_comb begin
        value = '0;
        cy    = 1'b0;
        ov    = 1'b0;
        known = 1'b1;
        wr_dest = 1'b0;
        unique case (op)
            OP_ADD: begin
                value   = sum_ext[MSB:0];
                cy      = sum_ext[DATA_W];
                ov      = add_ovf;
                wr_dest = 1'b1;
            end
            OP_SUB: begin
                value   = dif_ext[MSB:0];
                cy      = dif_ext[DATA_W];
                ov      = sub_ovf;
                wr_dest = 1'b1;
            end
            OP_CMP: begin
                value = dif_ext[MSB:0];
                cy    = dif_ext[DATA_W];
                ov    = sub_ovf;
            end
            OP_AND: begin
                value   = a & b;
                wr_dest = 1'b1;
            end
            OP_OR: begin
                value   = a | b;
                wr_dest = 1'b1;
            end
            OP_XOR: begin
                value   = a ^ b;
                wr_dest = 1'b1;
            end
            OP_RSV6, OP_RSV7: begin
                known = 1'b0;
            end
        endcase
        next_flags.c = cy;
        next_flags.z = (value == '0);
        next_flags.s = value[MSB];
        next_flags.o = ov;
        upd_flags    = op_valid && known;
        wr_dest      = wr_dest && op_valid;
    end

endmodule

// File: rtl/fl_status.sv
module fl_status
    import fl_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_flags,
    input  logic              wr_dest,
    input  flags_t            next_flags,
    input  logic [DATA_W-1:0] value,
    output flags_t            flags_q,
    output logic [DATA_W-1:0] result_q,
    output logic              we_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q  <= '0;
            result_q <= '0;
            we_q     <= 1'b0;
        end else begin
            we_q <= wr_dest;
            if (upd_flags) begin
                flags_q <= next_flags;
            end
            if (wr_dest) begin
                result_q <= value;
            end
        end
    end

    // R7: nothing changes without an accepted op
    a_r7_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_flags && !wr_dest) |=> ($stable(flags_q) && $stable(result_q) && !we_q));

    // R5: written result and stored zero/sign flags agree
    a_r5_zero_sign_match: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> ((flags_q.z == (result_q == '0)) && (flags_q.s == result_q[DATA_W-1])));

endmodule

// File: rtl/fl_cond.sv
module fl_cond
    import fl_pkg::*;
(
    input  flags_t          flags,
    input  logic [CC_W-1:0] cond_sel,
    output logic            take
);
    logic [CC_COUNT-1:0] pred;

    for (genvar i = 0; i < CC_COUNT; i++) begin : g_pred
        assign pred[i] = cc_eval(CC_W'(i), flags);
    end

    assign take = pred[cond_sel];

    always_comb begin
        // R9: the unconditional code always takes the branch
        a_r9_always_taken: assert (!(cond_sel == CC_ALWAYS) || take);
        // R10: greater and less-or-equal are complementary
        a_r10_gt_le_split: assert (pred[CC_SGT] != pred[CC_SLE]);
    end

endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
    import fl_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [3:0]        cond_sel,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_o,
    output logic              take_branch
);
    logic [DATA_W-1:0] value;
    flags_t            next_flags;
    flags_t            flags_q;
    logic              upd_flags;
    logic              wr_dest;

    fl_arith #(.DATA_W(DATA_W)) u_arith (
        .op_valid   (op_valid),
        .op_sel     (op_sel),
        .a          (opnd_a),
        .b          (opnd_b),
        .value      (value),
        .next_flags (next_flags),
        .upd_flags  (upd_flags),
        .wr_dest    (wr_dest)
    );

    fl_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_flags  (upd_flags),
        .wr_dest    (wr_dest),
        .next_flags (next_flags),
        .value      (value),
        .flags_q    (flags_q),
        .result_q   (result),
        .we_q       (result_we)
    );

    fl_cond u_cond (
        .flags    (flags_q),
        .cond_sel (cond_sel),
        .take     (take_branch)
    );

    assign flag_c = flags_q.c;
    assign flag_z = flags_q.z;
    assign flag_s = flags_q.s;
    assign flag_o = flags_q.o;

    // R4: a compare never requests a destination write
    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_CMP) |=> (!result_we && $stable(result)));

    // R6: logical ops leave carry and overflow clear
    a_r6_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR))
        |=> (!flag_c && !flag_o));

    // R7: idle cycles keep the status register
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable({flag_c, flag_z, flag_s, flag_o}) && !result_we));

    // R8: a writing op raises the strobe on the next cycle
    a_r8_we_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR}) |=> result_we);

endmodule

// File: tb/sim_flag_branch_unit.sv
module sim_flag_branch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [3:0]  cond_sel = '0;
    logic [63:0] result;
    logic        result_we;
    logic        flag_c, flag_z, flag_s, flag_o;
    logic        take_branch;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    flag_branch_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .cond_sel(cond_sel),
        .result(result), .result_we(result_we),
        .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o),
        .take_branch(take_branch)
    );

    typedef struct {
        logic        we;
        logic [63:0] res;
        logic [3:0]  fl;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] mdl_res = '0;
    logic [3:0]  mdl_fl  = '0;
    logic        chk_due = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) chk_due <= rst_n && op_valid;

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (chk_due) begin
                if (sb.size() == 0) begin
                    check("R8 unexpected output", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.req, " we"}, {63'd0, result_we}, {63'd0, e.we});
                    check({e.req, " result"}, result, e.res);
                    check({e.req, " flags czso"}, {60'd0, flag_c, flag_z, flag_s, flag_o}, {60'd0, e.fl});
                end
            end else begin
                check("R8 idle we", {63'd0, result_we}, 64'd0);
            end
        end
    end

    // driver: computes the expectation, pushes it, drives the op
    task automatic issue(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b, input string req);
        exp_t e;
        logic signed [65:0] wide;
        logic [63:0] v;
        logic c, o, we, known;
        c = 0; o = 0; we = 1; known = 1; v = '0;
        case (op)
            3'd0: begin
                v = a + b; c = (v < a);
                wide = $signed({{2{a[63]}}, a}) + $signed({{2{b[63]}}, b});
                o = (wide > 66'sh0_7FFF_FFFF_FFFF_FFFF) || (wide < -66'sh0_8000_0000_0000_0000);
            end
            3'd1, 3'd2: begin
                v = a - b; c = (a < b);
                wide = $signed({{2{a[63]}}, a}) - $signed({{2{b[63]}}, b});
                o = (wide > 66'sh0_7FFF_FFFF_FFFF_FFFF) || (wide < -66'sh0_8000_0000_0000_0000);
                if (op == 3'd2) we = 0;
            end
            3'd3: v = a & b;
            3'd4: v = a | b;
            3'd5: v = a ^ b;
            default: begin known = 0; we = 0; end
        endcase
        if (known) mdl_fl = {c, (v == 64'd0), v[63], o};
        if (we) mdl_res = v;
        e.we = we; e.res = mdl_res; e.fl = mdl_fl; e.req = req;
        @(negedge clk);
        sb.push_back(e);
        op_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
        end
    endtask

    // compare a with b, then test all 16 predicates against direct comparisons
    task automatic sweep(input logic [63:0] a, input logic [63:0] b);
        logic [63:0] d;
        logic exp;
        issue(3'd2, a, b, "R4 cmp");
        idle(2);
        d = a - b;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            cond_sel = 4'(c);
            #1;
            case (c)
                0: exp = 1'b1;
                1: exp = (a == b);
                2: exp = (a != b);
                3: exp = d[63];
                4: exp = !d[63];
                5: exp = ($signed(a) > $signed(b));
                6: exp = ($signed(a) >= $signed(b));
                7: exp = ($signed(a) < $signed(b));
                8: exp = ($signed(a) <= $signed(b));
                9: exp = (a > b);
                10: exp = (a < b);
                default: exp = 1'b0;
            endcase
            if (c <= 4)      check($sformatf("R9 cond %0d a=%h b=%h", c, a, b), {63'd0, take_branch}, {63'd0, exp});
            else if (c <= 8) check($sformatf("R10 cond %0d a=%h b=%h", c, a, b), {63'd0, take_branch}, {63'd0, exp});
            else             check($sformatf("R11 cond %0d a=%h b=%h", c, a, b), {63'd0, take_branch}, {63'd0, exp});
        end
    endtask

    initial begin
        #500000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 result", result, 64'd0);
        check("R1 we", {63'd0, result_we}, 64'd0);
        check("R1 flags", {60'd0, flag_c, flag_z, flag_s, flag_o}, 64'd0);
        cond_sel = 4'd0; #1;
        check("R1 always", {63'd0, take_branch}, 64'd1);
        cond_sel = 4'd1; #1;
        check("R1 eq", {63'd0, take_branch}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 add
        issue(3'd0, 64'd20, 64'd22, "R2 add plain");
        issue(3'd0, ONES, 64'd1, "R2 add carry to zero");
        issue(3'd0, MAXP, 64'd1, "R2 add signed overflow");
        issue(3'd0, MINN, MINN, "R2 add both overflows");
        // R3 subtract, back-to-back (R8)
        issue(3'd1, 64'd5, 64'd7, "R3 sub borrow");
        issue(3'd1, MINN, 64'd1, "R3 sub overflow");
        issue(3'd1, 64'd9, 64'd9, "R5 sub zero");
        idle(1);
        // R4 compare keeps result
        issue(3'd0, 64'h1234, 64'h1, "R2 add before cmp");
        issue(3'd2, 64'd3, 64'd4, "R4 cmp borrow keeps result");
        // R6 logic clears carry/overflow set beforehand
        issue(3'd1, MINN, 64'd1, "R3 sub set c/o");
        issue(3'd3, ONES, 64'h0F0F, "R6 and");
        issue(3'd0, ONES, ONES, "R2 add carry set");
        issue(3'd4, MINN, 64'd1, "R6 or negative");
        issue(3'd5, 64'hAA, 64'hAA, "R6 xor zero");
        // R7 unused codes
        issue(3'd1, 64'd1, 64'd2, "R3 sub set flags");
        issue(3'd6, 64'd0, 64'd0, "R7 op6 ignored");
        issue(3'd7, ONES, 64'd5, "R7 op7 ignored");
        idle(4);
        check("R7 idle flags", {60'd0, flag_c, flag_z, flag_s, flag_o}, {60'd0, mdl_fl});
        check("R7 idle result", result, mdl_res);
        // branch predicates
        sweep(64'd5, 64'd5);
        sweep(64'd3, 64'd9);
        sweep(ONES, 64'd1);
        sweep(MINN, 64'd1);
        sweep(64'd1, MINN);
        sweep(MAXP, ONES);
        sweep(64'd0, 64'd0);
        idle(2);
        check("R8 queue drained", 64'(sb.size()), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule